// File: doc/BRIEF.md
# Programmable Eight-Level Interrupt Controller

This block gathers eight edge-sensitive interrupt request lines into one interrupt signal for a processor. It keeps a request register, an in-service register and a mask register. It picks the winning level by walking the eight levels from a base that can be rotated. A small register port, selected by one address bit, lets software program it. Software first sends an initialization sequence, then uses operation commands to mask levels, end service, rotate priority, choose which register is read back, or poll.

The processor can take an interrupt in one of two ways. It can run an acknowledge sequence on the `inta` strobe: two cycles in the 16-bit style or three cycles in the 8-bit call style. It can instead poll through the register port. The winning level is latched on the first acknowledge cycle and held until the last one, so a later request of higher priority cannot change the vector halfway through a sequence. Cascading and buffered operation are not part of this block.

All register side effects take effect on the rising clock edge during a one-cycle `wr`, `rd` or `inta` strobe. `dout` is combinational and valid during the strobe cycle.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset, `intr` is 0. The mask, in-service and request registers are 0. An `a0`=1 read returns 0x00, and an `a0`=0 read returns 0x00.
- R2: A request bit is set when its `irq` line rises, as seen at a clock edge. A line that stays high does not set the bit again once an acknowledge or poll has cleared it.
- R3: In the ready state, a write with `a0`=1 loads the mask, and an `a0`=1 read returns the mask. A masked request never raises `intr`.
- R4: The search visits levels base, base+1, … (mod 8). The first unmasked requested level wins, unless an in-service level comes earlier in the walk or is the same level, in which case nothing wins. `intr` is 1 when there is a winner or an acknowledge sequence is in progress.
- R5: A write with `a0`=0 and data bit 4 set stores the first init word. It also clears the mask, in-service bits, priority base, auto-EOI, the 16-bit mode flag, poll and read select, and any acknowledge in progress. The next `a0`=1 write is the vector base. A cascade word follows only when bit 1 was 0, and a mode word follows only when bit 0 was 1. In the mode word, bit 0 selects the two-cycle acknowledge and bit 1 enables auto-EOI.
- R6: A write with `a0`=0, bit 4=0 and bit 3=1 is a read/poll command. When its bit 1 is set, bit 0 selects what an `a0`=0 read returns: 1 for in-service, 0 for request. After init, the request register is returned.
- R7: When the command's bit 2 is set, the next `a0`=0 read returns 0x80|level and puts that level in service, or returns 0x00 if there is no winner. Poll then turns off.
- R8: In two-cycle mode, the first acknowledge cycle returns 0xFF and puts the winner in service. The second returns {vector[7:3], level}.
- R9: In three-cycle mode, the bytes are 0xCD, then a low byte, then the vector base. The low byte is {init[7:5], level, 2'b00} when init bit 2 is 1, and {init[7:6], level, 3'b000} otherwise.
- R10: With auto-EOI, the last acknowledge cycle clears the in-service bit of the level it served.
- R11: A write with `a0`=0, bits 4:3=00 is an end command, decoded from bits 7:5. 001 clears the highest-priority in-service bit, found by walking from the base. 011 clears the bit named by bits 2:0.
- R12: Code 101 is a non-specific clear that also sets base = cleared level+1. Code 111 is a specific clear that sets base = bits 2:0 + 1. Code 110 only sets base = bits 2:0 + 1.
- R13: The level chosen on the first acknowledge cycle is used for every byte of the sequence, even if a higher request arrives in the middle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a0 | input | 1 | Register port address bit |
| wr | input | 1 | Write strobe, one cycle |
| rd | input | 1 | Read strobe, one cycle |
| din | input | 8 | Write data |
| dout | output | 8 | Read or acknowledge data, combinational |
| irq | input | 8 | Interrupt request lines |
| inta | input | 1 | Acknowledge strobe, one cycle per byte |
| intr | output | 1 | Interrupt to the processor |

## Verification
A rising request line is caught at the next clock edge, and `intr` follows it straight after that edge. The bench therefore samples `intr` one falling edge after it raises a line. Read and acknowledge bytes are combinational from the state present at the start of the strobe cycle, so they are sampled 1 ns after the falling edge that starts the strobe. Effects of a write, poll or acknowledge, such as in-service bits, base and mask, are visible from the cycle after the strobe, and the bench reads them back in a later strobe.

// File: rtl/irq_ctrl8.sv
module irq_ctrl8 #(
  parameter int LEVELS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a0,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] din,
  output logic [7:0] dout,
  input  logic [7:0] irq,
  input  logic       inta,
  output logic       intr
);
  localparam int LW = $clog2(LEVELS);

  typedef enum logic [1:0] {S_RDY, S_W2, S_W3, S_W4} st_t;

  st_t           st;
  logic [7:0]    irr, isr, imr, irq_q, icw1, icw2;
  logic [LW-1:0] base, hold, best, top;
  logic [1:0]    cnt;
  logic          m86, aeoi, poll, risel, found, top_f;

  always_comb begin
    logic stop;
    logic [LW-1:0] j;
    found = 1'b0; best = '1; stop = 1'b0;
    for (int i = 0; i < LEVELS; i++) begin
      j = base + LW'(i);
      if (!stop) begin
        if (isr[j]) stop = 1'b1;
        else if (irr[j] && !imr[j]) begin found = 1'b1; best = j; stop = 1'b1; end
      end
    end
  end

  always_comb begin
    logic [LW-1:0] j;
    top_f = 1'b0; top = '0;
    for (int i = LEVELS - 1; i >= 0; i--) begin
      j = base + LW'(i);
      if (isr[j]) begin top_f = 1'b1; top = j; end
    end
  end

  wire           last = m86 ? (cnt == 2'd1) : (cnt == 2'd2);
  wire [LW-1:0]  lvl  = (cnt == 2'd0) ? best : hold;
  assign intr = (cnt != 2'd0) || found;

  always_comb begin
    if (inta) begin
      if (cnt == 2'd0)       dout = m86 ? 8'hFF : 8'hCD;
      else if (m86)          dout = {icw2[7:3], lvl};
      else if (cnt == 2'd1)  dout = icw1[2] ? {icw1[7:5], lvl, 2'b00} : {icw1[7:6], lvl, 3'b000};
      else                   dout = icw2;
    end else if (a0)         dout = imr;
    else if (poll)           dout = found ? {5'b10000, best} : 8'h00;
    else                     dout = risel ? isr : irr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_RDY; irr <= '0; isr <= '0; imr <= '0; irq_q <= '0;
      icw1 <= '0; icw2 <= '0; base <= '0; hold <= '0; cnt <= '0;
      m86 <= 1'b0; aeoi <= 1'b0; poll <= 1'b0; risel <= 1'b0;
    end else begin
      irq_q <= irq;
      irr   <= irr | (irq & ~irq_q);
      if (wr) begin
        if (!a0 && din[4]) begin
          icw1 <= din; imr <= '0; isr <= '0; base <= '0; cnt <= '0;
          aeoi <= 1'b0; m86 <= 1'b0; poll <= 1'b0; risel <= 1'b0;
          st <= S_W2;
        end else if (!a0 && din[3]) begin
          if (din[1]) risel <= din[0];
          poll <= din[2];
        end else if (!a0) begin
          case (din[7:5])
            3'b001: if (top_f) isr[top] <= 1'b0;
            3'b101: if (top_f) begin isr[top] <= 1'b0; base <= top + LW'(1); end
            3'b011: isr[din[2:0]] <= 1'b0;
            3'b111: begin isr[din[2:0]] <= 1'b0; base <= din[2:0] + LW'(1); end
            3'b110: base <= din[2:0] + LW'(1);
            default: ;
          endcase
        end else begin
          case (st)
            S_RDY: imr <= din;
            S_W2: begin
              icw2 <= din;
              st <= !icw1[1] ? S_W3 : (icw1[0] ? S_W4 : S_RDY);
            end
            S_W3: st <= icw1[0] ? S_W4 : S_RDY;
            S_W4: begin m86 <= din[0]; aeoi <= din[1]; st <= S_RDY; end
            default: st <= S_RDY;
          endcase
        end
      end
      if (rd && !a0 && poll) begin
        poll <= 1'b0;
        if (found) begin isr[best] <= 1'b1; irr[best] <= 1'b0; end
      end
      if (inta) begin
        if (cnt == 2'd0) begin
          hold <= best; cnt <= 2'd1;
          if (found) begin isr[best] <= 1'b1; irr[best] <= 1'b0; end
        end else if (last) begin
          cnt <= 2'd0;
          if (aeoi) isr[hold] <= 1'b0;
        end else cnt <= cnt + 2'd1;
      end
    end
  end
endmodule

// File: rtl/irq_ctrl8_chk.sv
module irq_ctrl8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       a0,
  input logic       wr,
  input logic       rd,
  input logic [7:0] din,
  input logic       inta,
  input logic [7:0] imr,
  input logic [7:0] isr,
  input logic [1:0] cnt,
  input logic [1:0] st,
  input logic [2:0] hold,
  input logic       m86,
  input logic       poll,
  input logic       found
);
  a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && a0 && st == 2'd0) |=> imr == $past(din));

  a_r5_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !a0 && din[4]) |=> (imr == 8'h00 && isr == 8'h00 && cnt == 2'd0));

  a_r7_poll_serves: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !a0 && poll && found && !inta && !wr) |=> $countones(isr) == $countones($past(isr)) + 1);

  a_r8_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (m86 && inta && cnt == 2'd1 && !wr) |=> cnt == 2'd0);

  a_r9_three_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (!m86 && inta && cnt == 2'd1 && !wr) |=> cnt == 2'd2);

  a_r9_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != 2'd3);

  a_r13_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 2'd0 && !wr) |=> hold == $past(hold));
endmodule

bind irq_ctrl8 irq_ctrl8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .a0(a0), .wr(wr), .rd(rd), .din(din), .inta(inta),
  .imr(imr), .isr(isr), .cnt(cnt), .st(st), .hold(hold), .m86(m86),
  .poll(poll), .found(found)
);

// File: tb/irq_ctrl8_tb.sv
module irq_ctrl8_tb;
  logic clk = 1'b0, rst_n = 1'b0, a0 = 1'b0, wr = 1'b0, rd = 1'b0, inta = 1'b0;
  logic [7:0] din = '0, irq = '0, dout, q;
  logic intr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_ctrl8 u_dut (.clk(clk), .rst_n(rst_n), .a0(a0), .wr(wr), .rd(rd), .din(din),
                   .dout(dout), .irq(irq), .inta(inta), .intr(intr));

  // {irq pattern, mask, expected poll byte}, priority base 0, nothing in service
  localparam logic [23:0] VEC [6] = '{
    {8'h0C, 8'h00, 8'h82}, {8'h0C, 8'h04, 8'h83}, {8'hFF, 8'hFE, 8'h80},
    {8'h80, 8'h00, 8'h87}, {8'h10, 8'h10, 8'h00}, {8'h50, 8'h00, 8'h84}};

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    a0 = a; din = d; wr = 1'b1; @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] r);
    a0 = a; rd = 1'b1; #1 r = dout; @(negedge clk); rd = 1'b0;
  endtask

  task automatic ack(output logic [7:0] r);
    inta = 1'b1; #1 r = dout; @(negedge clk); inta = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] p);
    irq = p; @(negedge clk); irq = '0; @(negedge clk);
  endtask

  task automatic poll_rd(output logic [7:0] r);
    wr_reg(1'b0, 8'h0C); rd_reg(1'b0, r);
  endtask

  task automatic drain();
    logic [7:0] r;
    wr_reg(1'b1, 8'h00);
    for (int n = 0; n < 8; n++) begin poll_rd(r); wr_reg(1'b0, 8'h20); end
  endtask

  task automatic init(input logic [7:0] w1, input logic [7:0] w2, input logic [7:0] w4);
    wr_reg(1'b0, w1); wr_reg(1'b1, w2);
    if (w1[0]) wr_reg(1'b1, w4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk({7'd0, intr}, 8'h00, "R1 intr after reset");
    @(negedge clk);
    rd_reg(1'b1, q); chk(q, 8'h00, "R1 mask after reset");
    rd_reg(1'b0, q); chk(q, 8'h00, "R1 request read after reset");

    // R5: cascade word expected when bit1=0, mode word when bit0=1
    wr_reg(1'b0, 8'h11); wr_reg(1'b1, 8'h40); wr_reg(1'b1, 8'h00); wr_reg(1'b1, 8'h01);
    wr_reg(1'b1, 8'hAA); rd_reg(1'b1, q); chk(q, 8'hAA, "R5 sequence with cascade word / R3 mask");
    init(8'h13, 8'h40, 8'h01);
    rd_reg(1'b1, q); chk(q, 8'h00, "R5 init clears mask");

    for (int k = 0; k < 6; k++) begin
      wr_reg(1'b1, VEC[k][15:8]);
      pulse(VEC[k][23:16]);
      chk({7'd0, intr}, {7'd0, VEC[k][7:0] != 8'h00}, "R3 R4 intr per vector");
      poll_rd(q); chk(q, VEC[k][7:0], "R4 R7 poll per vector");
      wr_reg(1'b0, 8'h20);
      drain();
    end

    // R4 in-service blocking, R6 read select
    pulse(8'h04); poll_rd(q); chk(q, 8'h82, "R7 poll level2");
    wr_reg(1'b0, 8'h0B); rd_reg(1'b0, q); chk(q, 8'h04, "R6 read in-service");
    pulse(8'h20); chk({7'd0, intr}, 8'h00, "R4 lower level blocked");
    wr_reg(1'b0, 8'h0A); rd_reg(1'b0, q); chk(q, 8'h20, "R6 read request / R2 edge captured");
    pulse(8'h01); chk({7'd0, intr}, 8'h01, "R4 higher level passes");
    drain();
    poll_rd(q); chk(q, 8'h00, "R7 poll empty");

    // R11 R12 rotation and end commands
    pulse(8'h04); poll_rd(q); chk(q, 8'h82, "R12 setup");
    wr_reg(1'b0, 8'hA0);
    pulse(8'h12); poll_rd(q); chk(q, 8'h84, "R12 rotate non-specific base 3");
    wr_reg(1'b0, 8'h20);
    poll_rd(q); chk(q, 8'h81, "R11 non-specific clear");
    wr_reg(1'b0, 8'h20);
    wr_reg(1'b0, 8'hC7);
    pulse(8'h12); poll_rd(q); chk(q, 8'h81, "R12 set priority base 0");
    wr_reg(1'b0, 8'h61);
    wr_reg(1'b0, 8'h0B); rd_reg(1'b0, q); chk(q, 8'h00, "R11 specific clear");
    poll_rd(q); chk(q, 8'h84, "R12 remaining level4");
    wr_reg(1'b0, 8'hE4);
    pulse(8'h41); poll_rd(q); chk(q, 8'h86, "R12 rotate specific base 5");
    drain();
    wr_reg(1'b0, 8'hC7);

    // R8 two-cycle acknowledge
    pulse(8'h20); chk({7'd0, intr}, 8'h01, "R8 intr");
    ack(q); chk(q, 8'hFF, "R8 first byte");
    ack(q); chk(q, 8'h45, "R8 vector");
    chk({7'd0, intr}, 8'h00, "R8 intr cleared");
    wr_reg(1'b0, 8'h0B); rd_reg(1'b0, q); chk(q, 8'h20, "R8 in service");
    wr_reg(1'b0, 8'h20);

    // R13 latched level
    pulse(8'h20); ack(q);
    irq = 8'h02; ack(q); chk(q, 8'h45, "R13 vector held");
    irq = 8'h00; @(negedge clk);
    chk({7'd0, intr}, 8'h01, "R13 higher request raises intr after");
    ack(q); ack(q); chk(q, 8'h41, "R13 next vector");
    drain();

    // R10 auto-EOI, R2 held line
    init(8'h13, 8'h40, 8'h03);
    irq = 8'h08; @(negedge clk);
    ack(q); ack(q); chk(q, 8'h43, "R10 vector");
    wr_reg(1'b0, 8'h0B); rd_reg(1'b0, q); chk(q, 8'h00, "R10 auto clear");
    wr_reg(1'b0, 8'h0A); rd_reg(1'b0, q); chk(q, 8'h00, "R2 held line not re-set");
    chk({7'd0, intr}, 8'h00, "R2 intr low with held line");
    irq = 8'h00; @(negedge clk);

    // R9 three-cycle acknowledge
    init(8'hB6, 8'h12, 8'h00);
    pulse(8'h40);
    ack(q); chk(q, 8'hCD, "R9 first byte");
    ack(q); chk(q, 8'hB8, "R9 low byte interval 4");
    ack(q); chk(q, 8'h12, "R9 high byte");
    wr_reg(1'b0, 8'h20);
    init(8'hD2, 8'h12, 8'h00);
    pulse(8'h40);
    ack(q); ack(q); chk(q, 8'hF0, "R9 low byte interval 8");
    ack(q);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule